// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog timer that sits on a simple register bus. A count register climbs by one on each slow time-base pulse. The pulses can first pass through an optional divider whose ratio is a power of two. If software stops servicing the watchdog, the count passes its all-ones value. The block then raises a reset request for one clock and starts counting again from the reload value. Software picks the timeout by choosing that reload value: a value closer to all ones gives a shorter timeout.

Writes from the bus are posted. Each write is held for a fixed number of bus cycles before it takes effect, which models a crossing into the slow clock domain. While a write is in flight, its own bit in a status word is set. Any further write to that same register is dropped until the bit clears. Arming and disarming each need a two-word key pair, written to one key register in order. A service kick reloads the count only when the written value differs from the last kick value that was accepted, so software alternates between a value and its inverse.

The bus is plain control and status: a write strobe with address and data, and a combinational read port. Writes are never stalled. The only back-pressure is the pending bit, which software polls before writing the same register again.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, the count, the control word, the stored kick value and the pending status all read zero, the watchdog is disarmed and `wdt_rst_o` is low.
- R2: Writes use address 0 for control, 1 for reload value, 2 for kick and 3 for key. Reads use the same addresses, plus 4 for pending status and 5 for the count. Status bit n belongs to write address n. A write accepted at a clock edge sets its status bit from that edge on. The write takes effect, and the bit clears, at the fourth edge after it.
- R3: A write to a register whose pending bit is still set is dropped and has no effect.
- R4: Writing 0x0000BBBB to the key register and then 0x00004444 as the next key write arms the watchdog. Bit 0 of a read at address 3 reads 1 when armed.
- R5: Writing 0x0000AAAA and then 0x00005555 as the next key write disarms the watchdog.
- R6: A first key followed by any other key-register write, or a second key written with no first key before it, leaves the armed state unchanged.
- R7: When the divider is off, each `tick_i` pulse adds one to the count while armed. While disarmed, the count holds.
- R8: Control bit 5 enables the divider and bits [4:2] give the ratio k. The count then advances once every 2^k armed ticks. The divider phase restarts when a control write lands.
- R9: A landed kick write whose value differs from the stored kick value loads the count from the reload register and stores the new kick value. A kick equal to the stored value does nothing.
- R10: An armed advance from all ones pulses `wdt_rst_o` high for exactly one cycle and loads the count from the reload register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Slow time-base pulse, one cycle wide |
| bus_wr_i | input | 1 | Write strobe |
| bus_waddr_i | input | ADDR_W | Write address |
| bus_wdata_i | input | 32 | Write data |
| bus_raddr_i | input | ADDR_W | Read address |
| bus_rdata_o | output | 32 | Read data, combinational |
| wdt_rst_o | output | 1 | One-cycle reset request on expiry |

## Verification
The bench builds the block with its default parameters: a 32-bit count, a four-cycle posting delay and a 3-bit divider ratio. The bench writes reload values a step or two below all ones, so wrap-around and the reset pulse are reached within a few ticks. The short posting delay lets the bench check the pending bit cycle by cycle, and place a second write inside the pending window. A divider ratio of 2 shows the four-tick cadence without long runs.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam int NUM_POST = 4;
  localparam int SLOT_CTRL = 0;
  localparam int SLOT_LOAD = 1;
  localparam int SLOT_KICK = 2;
  localparam int SLOT_KEY  = 3;
  localparam int RADDR_PEND  = 4;
  localparam int RADDR_COUNT = 5;

  localparam logic [31:0] KEY_ARM_A = 32'h0000_BBBB;
  localparam logic [31:0] KEY_ARM_B = 32'h0000_4444;
  localparam logic [31:0] KEY_DIS_A = 32'h0000_AAAA;
  localparam logic [31:0] KEY_DIS_B = 32'h0000_5555;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARM_1 = 2'd1,
    SEQ_DIS_1 = 2'd2
  } seq_state_t;
endpackage

// File: rtl/wdt_post_slot.sv
`timescale 1ns/1ps
module wdt_post_slot #(
  parameter int DW  = 32,
  parameter int DLY = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  output logic          pend_o,
  output logic          land_o,
  output logic [DW-1:0] data_o
);
  localparam int CW = (DLY < 2) ? 1 : $clog2(DLY);

  logic          pend_q;
  logic [CW-1:0] wait_q;
  logic [DW-1:0] hold_q;
  logic          accept;

  assign accept = wr_i && !pend_q;
  assign land_o = pend_q && (wait_q == '0);
  assign pend_o = pend_q;
  assign data_o = hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      wait_q <= '0;
      hold_q <= '0;
    end else if (accept) begin
      pend_q <= 1'b1;
      wait_q <= CW'(DLY - 1);
      hold_q <= data_i;
    end else if (land_o) begin
      pend_q <= 1'b0;
    end else if (pend_q) begin
      wait_q <= wait_q - 1'b1;
    end
  end

  assert_pend_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !land_o) |=> pend_q);
  assert_pend_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    land_o |=> !pend_q);
  assert_drop_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && wr_i) |=> $stable(hold_q));
endmodule

// File: rtl/wdt_key_seq.sv
`timescale 1ns/1ps
module wdt_key_seq
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        land_i,
  input  logic [31:0] key_i,
  output logic        armed_o
);
  seq_state_t st_q, st_d;
  logic       armed_q, armed_d;

  always_comb begin
    st_d    = st_q;
    armed_d = armed_q;
    if (land_i) begin
      unique case (st_q)
        SEQ_IDLE: begin
          if (key_i == KEY_ARM_A)      st_d = SEQ_ARM_1;
          else if (key_i == KEY_DIS_A) st_d = SEQ_DIS_1;
          else                         st_d = SEQ_IDLE;
        end
        SEQ_ARM_1: begin
          if (key_i == KEY_ARM_B) armed_d = 1'b1;
          st_d = SEQ_IDLE;
        end
        SEQ_DIS_1: begin
          if (key_i == KEY_DIS_B) armed_d = 1'b0;
          st_d = SEQ_IDLE;
        end
        default: st_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SEQ_IDLE;
      armed_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      armed_q <= armed_d;
    end
  end

  assign armed_o = armed_q;

  assert_arm_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (land_i && st_q == SEQ_ARM_1 && key_i == KEY_ARM_B) |=> armed_o);
  assert_disarm_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (land_i && st_q == SEQ_DIS_1 && key_i == KEY_DIS_B) |=> !armed_o);
  assert_abandon_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (land_i && st_q == SEQ_IDLE) |=> $stable(armed_o));
endmodule

// File: rtl/wdt_count_core.sv
`timescale 1ns/1ps
module wdt_count_core #(
  parameter int CNT_W = 32,
  parameter int PTV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             armed_i,
  input  logic             pre_en_i,
  input  logic [PTV_W-1:0] ratio_i,
  input  logic             pre_clr_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] count_o,
  output logic             bite_o
);
  localparam int PW = (1 << PTV_W) - 1;

  logic [PW-1:0]    pre_q;
  logic [PW:0]      lim_full;
  logic [PW-1:0]    limit;
  logic             step;
  logic             at_top;
  logic [CNT_W-1:0] count_q;
  logic             bite_q;

  assign lim_full = ({{PW{1'b0}}, 1'b1} << ratio_i) - 1'b1;
  assign limit    = lim_full[PW-1:0];
  assign step     = tick_i && armed_i && (!pre_en_i || pre_q == limit);
  assign at_top   = &count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (pre_clr_i || !armed_i) begin
      pre_q <= '0;
    end else if (tick_i && pre_en_i) begin
      pre_q <= (pre_q == limit) ? '0 : pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      bite_q  <= 1'b0;
    end else begin
      bite_q <= step && at_top && !reload_i;
      if (reload_i)     count_q <= load_i;
      else if (step)    count_q <= at_top ? load_i : count_q + 1'b1;
    end
  end

  assign count_o = count_q;
  assign bite_o  = bite_q;

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_i && !reload_i) |=> $stable(count_q));
  assert_prescale_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_i && pre_en_i && pre_q != limit && !reload_i) |=> $stable(count_q));
  assert_expire_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_top && !reload_i) |=> (bite_q && count_q == $past(load_i)));
  assert_one_shot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bite_q && !(&load_i)) |=> !bite_q);
endmodule

// File: rtl/wdt_keyed.sv
`timescale 1ns/1ps
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int CNT_W   = 32,
  parameter int PTV_W   = 3,
  parameter int DLY     = 4,
  parameter int PTV_LSB = 2,
  parameter int PRE_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_waddr_i,
  input  logic [31:0]       bus_wdata_i,
  input  logic [ADDR_W-1:0] bus_raddr_i,
  output logic [31:0]       bus_rdata_o,
  output logic              wdt_rst_o
);
  logic [NUM_POST-1:0] pend;
  logic [NUM_POST-1:0] land;
  logic [31:0]         slot_data [NUM_POST];

  for (genvar i = 0; i < NUM_POST; i++) begin : g_slot
    wdt_post_slot #(.DW(32), .DLY(DLY)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (bus_wr_i && (bus_waddr_i == ADDR_W'(i))),
      .data_i (bus_wdata_i),
      .pend_o (pend[i]),
      .land_o (land[i]),
      .data_o (slot_data[i])
    );
  end

  logic             pre_en_q;
  logic [PTV_W-1:0] ratio_q;
  logic [CNT_W-1:0] load_q;
  logic [31:0]      kick_q;
  logic             reload;
  logic             armed;
  logic [CNT_W-1:0] count;

  assign reload = land[SLOT_KICK] && (slot_data[SLOT_KICK] != kick_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_en_q <= 1'b0;
      ratio_q  <= '0;
      load_q   <= '0;
      kick_q   <= '0;
    end else begin
      if (land[SLOT_CTRL]) begin
        pre_en_q <= slot_data[SLOT_CTRL][PRE_BIT];
        ratio_q  <= slot_data[SLOT_CTRL][PTV_LSB +: PTV_W];
      end
      if (land[SLOT_LOAD]) load_q <= slot_data[SLOT_LOAD][CNT_W-1:0];
      if (reload)          kick_q <= slot_data[SLOT_KICK];
    end
  end

  wdt_key_seq u_keys (
    .clk     (clk),
    .rst_n   (rst_n),
    .land_i  (land[SLOT_KEY]),
    .key_i   (slot_data[SLOT_KEY]),
    .armed_o (armed)
  );

  wdt_count_core #(.CNT_W(CNT_W), .PTV_W(PTV_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .armed_i   (armed),
    .pre_en_i  (pre_en_q),
    .ratio_i   (ratio_q),
    .pre_clr_i (land[SLOT_CTRL]),
    .reload_i  (reload),
    .load_i    (load_q),
    .count_o   (count),
    .bite_o    (wdt_rst_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (int'(bus_raddr_i))
      SLOT_CTRL: begin
        bus_rdata_o[PRE_BIT]           = pre_en_q;
        bus_rdata_o[PTV_LSB +: PTV_W]  = ratio_q;
      end
      SLOT_LOAD:   bus_rdata_o = 32'(load_q);
      SLOT_KICK:   bus_rdata_o = kick_q;
      SLOT_KEY:    bus_rdata_o = {31'b0, armed};
      RADDR_PEND:  bus_rdata_o = 32'(pend);
      RADDR_COUNT: bus_rdata_o = 32'(count);
      default:     bus_rdata_o = '0;
    endcase
  end

  assert_kick_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (count == $past(load_q)));
  assert_same_kick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (land[SLOT_KICK] && !reload) |=> $stable(kick_q));
endmodule

// File: tb/wdt_keyed_test.sv
`timescale 1ns/1ps
module wdt_keyed_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic [2:0]  bus_waddr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [2:0]  bus_raddr_i = '0;
  logic [31:0] bus_rdata_o;
  logic        wdt_rst_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  wdt_keyed uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .bus_wr_i(bus_wr_i), .bus_waddr_i(bus_waddr_i), .bus_wdata_i(bus_wdata_i),
    .bus_raddr_i(bus_raddr_i), .bus_rdata_o(bus_rdata_o), .wdt_rst_o(wdt_rst_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    bus_raddr_i = 3'(a);
    #0.5;
    v = bus_rdata_o;
  endtask

  task automatic chk_rd(input string req, input int a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic wr_raw(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_i = 1'b1; bus_waddr_i = 3'(a); bus_wdata_i = d;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic wl(input int a, input logic [31:0] d);
    wr_raw(a, d);
    repeat (4) @(negedge clk);
  endtask

  task automatic tick1();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
  endtask

  task automatic t_reset();
    chk_rd("R1 ctrl", 0, 0);
    chk_rd("R1 kick", 2, 0);
    chk_rd("R1 armed", 3, 0);
    chk_rd("R1 pend", 4, 0);
    chk_rd("R1 count", 5, 0);
    check("R1 rst_o", 32'(wdt_rst_o), 0);
  endtask

  task automatic t_post();
    wr_raw(1, 32'h200);
    chk_rd("R2 pend set", 4, 32'h2);
    repeat (3) @(negedge clk);
    chk_rd("R2 pend still", 4, 32'h2);
    chk_rd("R2 load early", 1, 0);
    @(negedge clk);
    chk_rd("R2 pend clear", 4, 0);
    chk_rd("R2 load landed", 1, 32'h200);
  endtask

  task automatic t_ignore();
    wr_raw(1, 32'h300);
    wr_raw(1, 32'h111);
    repeat (3) @(negedge clk);
    chk_rd("R3 busy write dropped", 1, 32'h300);
    chk_rd("R3 pend clear", 4, 0);
  endtask

  task automatic t_kick();
    wl(2, 32'h1);
    chk_rd("R9 kick reload", 5, 32'h300);
    wl(1, 32'h50);
    wl(2, 32'h1);
    chk_rd("R9 same kick", 5, 32'h300);
    wl(2, 32'hFFFF_FFFE);
    chk_rd("R9 new kick", 5, 32'h50);
    chk_rd("R9 kick stored", 2, 32'hFFFF_FFFE);
  endtask

  task automatic t_arm();
    tick1();
    chk_rd("R7 disarmed hold", 5, 32'h50);
    wl(3, 32'h0000_BBBB);
    chk_rd("R4 half key", 3, 0);
    wl(3, 32'h0000_4444);
    chk_rd("R4 armed", 3, 1);
    tick1();
    chk_rd("R7 step 1", 5, 32'h51);
    tick1();
    chk_rd("R7 step 2", 5, 32'h52);
  endtask

  task automatic t_prescale();
    wl(0, 32'h28);
    chk_rd("R8 ctrl read", 0, 32'h28);
    repeat (3) tick1();
    chk_rd("R8 divided hold", 5, 32'h52);
    tick1();
    chk_rd("R8 fourth tick", 5, 32'h53);
    wl(0, 32'h0);
    tick1();
    chk_rd("R8 divider off", 5, 32'h54);
  endtask

  task automatic t_sequence();
    wl(3, 32'h0000_AAAA);
    wl(3, 32'h0000_1234);
    wl(3, 32'h0000_5555);
    chk_rd("R6 broken disarm", 3, 1);
    wl(3, 32'h0000_5555);
    chk_rd("R6 lone second key", 3, 1);
    tick1();
    chk_rd("R6 still counting", 5, 32'h55);
    wl(3, 32'h0000_AAAA);
    wl(3, 32'h0000_5555);
    chk_rd("R5 disarmed", 3, 0);
    tick1();
    chk_rd("R5 count frozen", 5, 32'h55);
    wl(3, 32'h0000_BBBB);
    wl(3, 32'h0000_AAAA);
    wl(3, 32'h0000_4444);
    chk_rd("R6 broken arm", 3, 0);
  endtask

  task automatic t_expire();
    wl(1, 32'hFFFF_FFFE);
    wl(2, 32'h1);
    chk_rd("R10 preload", 5, 32'hFFFF_FFFE);
    wl(3, 32'h0000_BBBB);
    wl(3, 32'h0000_4444);
    tick1();
    chk_rd("R10 at top", 5, 32'hFFFF_FFFF);
    check("R10 no pulse yet", 32'(wdt_rst_o), 0);
    tick1();
    check("R10 pulse", 32'(wdt_rst_o), 1);
    chk_rd("R10 reloaded", 5, 32'hFFFF_FFFE);
    @(negedge clk);
    check("R10 pulse one cycle", 32'(wdt_rst_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_post();
    t_ignore();
    t_kick();
    t_arm();
    t_prescale();
    t_sequence();
    t_expire();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule